// File: doc/BRIEF.md
# Byte Instruction Prefetch Queue

This block sits between a bus interface and an instruction consumer. It fetches 16-bit words from memory, one request at a time, and keeps the fetched bytes in a small first-in-first-out store. The consumer takes the bytes out one per request. The block produces the next fetch address itself and issues a new request only when there is room for a whole word. A word fetched from an odd address contributes only its upper byte. After that fetch, fetching continues at the following even address.

A taken branch is signalled with a flush and a new target address. The flush empties the store and reloads the fetch pointer. Any fetch response that arrives in the flush cycle is discarded, and so is any response still outstanding from before the flush. When the store is empty, the first byte of an arriving word is offered to the consumer in the same cycle, so a branch target costs no extra cycle.

Top module: `prefetch_queue`

## Requirements
- R1: After reset, `popValid` is low, `memReq` is high and `memAddr` equals the `RESET_ADDR` parameter (0 by default).
- R2: `memReq` is high exactly when no fetch is outstanding, `flushValid` is low and at least two byte slots are free. `memAddr` is always even. A request counts as outstanding from its cycle until the cycle in which `memValid` is high.
- R3: A response to an even fetch pointer queues two bytes: `memData[7:0]` (the even address) first, then `memData[15:8]`. The fetch pointer then advances by 2.
- R4: A response to an odd fetch pointer queues only `memData[15:8]`. The fetch pointer then advances by 1, to the next even address.
- R5: Bytes leave in arrival order, one per cycle in which `popReq` and `popValid` are both high. `popData` holds its value while the byte at the head is not popped. The store holds up to `DEPTH` (6) bytes.
- R6: When the store is empty and a response is accepted, `popValid` rises in that same cycle and `popData` carries the first byte of the response.
- R7: While `flushValid` is high, `popValid` is low. The store is emptied, and the next request uses the even address at or below `flushAddr`. When `flushAddr` is odd, that first response yields only its upper byte, as in R4.
- R8: A response that arrives in a flush cycle, or that answers a request made before the flush, is dropped: none of its bytes are ever offered.
- R9: A push and a pop in the same cycle both take effect, and the byte count stays exact.
- R10: `popReq` while nothing is available changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flushValid | input | 1 | Branch taken: discard bytes and restart fetching |
| flushAddr | input | ADDR_W | Byte address of the branch target |
| memReq | output | 1 | Word fetch request, one cycle per request |
| memAddr | output | ADDR_W | Even word address of the request |
| memValid | input | 1 | Fetch response present |
| memData | input | 16 | Fetched word, even-address byte in the low half |
| popReq | input | 1 | Consumer takes the offered byte |
| popValid | output | 1 | A byte is offered |
| popData | output | 8 | The offered byte |

## Verification
The bench builds the block with `DEPTH` = 6 and `ADDR_W` = 8. The 8-bit address makes the fetch pointer wrap past 0xFF within a short run, and an odd-multiplier byte pattern gives every address a distinct value, so a byte that is misordered, duplicated or wrongly dropped shows up at once. The bench sweeps response latencies of 1 to 3 cycles, start addresses of both parities and four consumer pop patterns. Flushes land at fixed cycles, so they meet empty, full, outstanding and coinciding-response states.

// File: rtl/pq_pkg.sv
package pq_pkg;
  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic flush;    // empty the store and load the fetch pointer
    logic wrFirst;  // write first incoming byte at the write pointer
    logic wrSecond; // write upper incoming byte after it
    logic pop;      // advance the read pointer
    logic adv1;     // fetch pointer += 1 (odd fetch)
    logic adv2;     // fetch pointer += 2 (even fetch)
  } pqStrobe_t;
endpackage

// File: rtl/pq_ctrl.sv
module pq_ctrl
  import pq_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      flushValid,
  input  logic      memValid,
  input  logic      popReq,
  input  logic      fetchOdd,
  output pqStrobe_t strobe,
  output logic      memReq,
  output logic      popValid,
  output logic      selBypass
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          pending;
  logic          stale;
  logic          accept, inTwo, emptyQ, bypassPop, popQ;
  logic [1:0]    nWr;

  assign accept    = memValid && !stale && !flushValid;
  assign inTwo     = accept && !fetchOdd;
  assign emptyQ    = (count == '0);
  assign bypassPop = emptyQ && accept && popReq;
  assign popQ      = !emptyQ && popReq && !flushValid;

  always_comb begin
    strobe          = '0;
    strobe.flush    = flushValid;
    strobe.wrFirst  = accept && !bypassPop;
    strobe.wrSecond = inTwo;
    strobe.pop      = popQ;
    strobe.adv1     = accept && fetchOdd;
    strobe.adv2     = inTwo;
  end

  assign nWr       = {1'b0, strobe.wrFirst} + {1'b0, strobe.wrSecond};
  assign popValid  = !flushValid && (!emptyQ || accept);
  assign selBypass = emptyQ;
  assign memReq    = !pending && !flushValid && (count <= CW'(DEPTH - 2));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      pending <= 1'b0;
      stale   <= 1'b0;
    end else begin
      if (flushValid) count <= '0;
      else            count <= count + CW'(nWr) - CW'(popQ);

      if (memValid)    pending <= 1'b0;
      else if (memReq) pending <= 1'b1;

      if (flushValid)    stale <= pending && !memValid;
      else if (memValid) stale <= 1'b0;
    end
  end
endmodule

// File: rtl/pq_datapath.sv
module pq_datapath
  import pq_pkg::*;
#(
  parameter int              DEPTH      = 6,
  parameter int              ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  pqStrobe_t         strobe,
  input  logic              selBypass,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic [15:0]       memData,
  output logic              fetchOdd,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        popData
);
  localparam int PW = $clog2(DEPTH);

  function automatic logic [PW-1:0] wrapAdd(logic [PW-1:0] p, logic [1:0] n);
    logic [PW:0] s;
    s = (PW+1)'(p) + (PW+1)'(n);
    if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
    return s[PW-1:0];
  endfunction

  logic [ADDR_W-1:0] fetchPtr;
  logic [PW-1:0]     rdPtr, wrPtr, secIdx;
  logic [7:0]        store [DEPTH];
  logic [7:0]        byte0, byte1;
  logic [1:0]        nWr;

  assign fetchOdd = fetchPtr[0];
  assign memAddr  = {fetchPtr[ADDR_W-1:1], 1'b0};
  assign byte0    = fetchOdd ? memData[15:8] : memData[7:0];
  assign byte1    = memData[15:8];
  assign secIdx   = strobe.wrFirst ? wrapAdd(wrPtr, 2'd1) : wrPtr;
  assign nWr      = {1'b0, strobe.wrFirst} + {1'b0, strobe.wrSecond};
  assign popData  = selBypass ? byte0 : store[rdPtr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.wrFirst && wrPtr == PW'(i))        store[i] <= byte0;
      else if (strobe.wrSecond && secIdx == PW'(i)) store[i] <= byte1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPtr <= RESET_ADDR;
      rdPtr    <= '0;
      wrPtr    <= '0;
    end else if (strobe.flush) begin
      fetchPtr <= flushAddr;
      rdPtr    <= '0;
      wrPtr    <= '0;
    end else begin
      if (strobe.adv2)      fetchPtr <= fetchPtr + ADDR_W'(2);
      else if (strobe.adv1) fetchPtr <= fetchPtr + ADDR_W'(1);
      wrPtr <= wrapAdd(wrPtr, nWr);
      if (strobe.pop) rdPtr <= wrapAdd(rdPtr, 2'd1);
    end
  end
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pq_pkg::*;
#(
  parameter int                DEPTH      = 6,
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [15:0]       memData,
  input  logic              popReq,
  output logic              popValid,
  output logic [7:0]        popData
);
  pqStrobe_t strobe;
  logic      fetchOdd;
  logic      selBypass;

  pq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .flushValid(flushValid), .memValid(memValid),
    .popReq(popReq), .fetchOdd(fetchOdd), .strobe(strobe), .memReq(memReq),
    .popValid(popValid), .selBypass(selBypass)
  );

  pq_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selBypass(selBypass),
    .flushAddr(flushAddr), .memData(memData), .fetchOdd(fetchOdd),
    .memAddr(memAddr), .popData(popData)
  );
endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              flushValid,
  input logic [ADDR_W-1:0] flushAddr,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memValid,
  input logic              popReq,
  input logic              popValid,
  input logic [7:0]        popData
);
  logic outstanding;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         outstanding <= 1'b0;
    else if (memValid) outstanding <= 1'b0;
    else if (memReq)   outstanding <= 1'b1;
  end

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !memReq); // R2

  AST_EVEN_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !memAddr[0]); // R2

  AST_FLUSH_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> !popValid); // R7

  AST_FLUSH_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(flushValid) && !flushValid && memReq)
      |-> memAddr == ($past(flushAddr) & ~ADDR_W'(1))); // R7

  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && !popReq && !flushValid)
      |=> (flushValid || (popValid && popData == $past(popData)))); // R5
endmodule

bind prefetch_queue prefetch_queue_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .flushValid(flushValid), .flushAddr(flushAddr),
  .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .popReq(popReq),
  .popValid(popValid), .popData(popData)
);

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 6;
  localparam int ADDR_W     = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              flushValid;
  logic [ADDR_W-1:0] flushAddr;
  logic              memReq;
  logic [ADDR_W-1:0] memAddr;
  logic              memValid;
  logic [15:0]       memData;
  logic              popReq;
  logic              popValid;
  logic [7:0]        popData;

  prefetch_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .flushValid(flushValid), .flushAddr(flushAddr),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .popReq(popReq), .popValid(popValid), .popData(popData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // memory responder state
  bit                memPend;
  int                pendLeft;
  int                lat;
  logic [ADDR_W-1:0] memReqAddr;

  // reference model state
  logic [7:0]        mq[$];
  bit                mOdd[$];
  logic [ADDR_W-1:0] mPtr;
  bit                mPend, mStale, lastOdd, lastFlush, prevSimul;

  function automatic logic [7:0] memByte(logic [ADDR_W-1:0] a);
    return 8'((int'(a) * 37 + 11) & 255);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; flushValid = 0; flushAddr = '0; memValid = 0; memData = '0; popReq = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    mq.delete(); mOdd.delete();
    mPtr = '0; mPend = 0; mStale = 0; lastOdd = 0; lastFlush = 0; prevSimul = 0;
    memPend = 0;
    #1;
    chk(popValid == 1'b0, "R1", popValid, 0);
    chk(memReq == 1'b1, "R1", memReq, 1);
    chk(memAddr == '0, "R1", memAddr, 0);
    if (memReq) begin memPend = 1; pendLeft = lat; memReqAddr = memAddr; end
    mPend = 1;
  endtask

  task automatic step(bit pop, bit fl, logic [ADDR_W-1:0] fa);
    int    nIn;
    bit    accept, expPV, expReq;
    logic [7:0] in0, in1, expD;
    string tag;
    @(posedge clk); #1;
    memValid = 0;
    if (memPend) begin
      pendLeft--;
      if (pendLeft == 0) begin
        memValid = 1;
        memData  = {memByte(memReqAddr + ADDR_W'(1)), memByte(memReqAddr)};
        memPend  = 0;
      end
    end
    popReq = pop; flushValid = fl; flushAddr = fa;
    #1;
    accept = memValid && !mStale && !fl;
    nIn = accept ? (mPtr[0] ? 1 : 2) : 0;
    in0 = mPtr[0] ? memData[15:8] : memData[7:0];
    in1 = memData[15:8];
    expPV = !fl && (mq.size() > 0 || nIn > 0);
    if (fl) tag = "R7";
    else if (memValid && mStale) tag = "R8";
    else if (prevSimul) tag = "R9";
    else if (mq.size() == 0 && nIn == 0 && pop) tag = "R10";
    else if (mq.size() == 0 && nIn > 0) tag = "R6";
    else tag = "R5";
    chk(popValid == expPV, tag, popValid, expPV);
    if (expPV && popValid) begin
      expD = (mq.size() > 0) ? mq[0] : in0;
      chk(popData == expD, (mq.size() > 0) ? (mOdd[0] ? "R4" : "R3") : "R6", popData, expD);
    end
    expReq = !fl && !mPend && (mq.size() <= DEPTH - 2);
    chk(memReq == expReq, "R2", memReq, expReq);
    if (memReq && expReq)
      chk(memAddr == {mPtr[ADDR_W-1:1], 1'b0}, lastFlush ? "R7" : (lastOdd ? "R4" : "R3"),
          memAddr, {mPtr[ADDR_W-1:1], 1'b0});
    // model update
    if (fl) begin
      mq.delete(); mOdd.delete();
      mStale = mPend && !memValid;
      if (memValid) mPend = 0;
      mPtr = fa; lastFlush = 1;
    end else begin
      if (memValid) begin mPend = 0; mStale = 0; end
      if (nIn > 0) begin
        mq.push_back(in0); mOdd.push_back(mPtr[0]);
        if (nIn == 2) begin mq.push_back(in1); mOdd.push_back(1'b0); end
        lastOdd = mPtr[0]; lastFlush = 0;
        mPtr = mPtr + ADDR_W'(nIn);
      end
      if (pop && expPV) begin void'(mq.pop_front()); void'(mOdd.pop_front()); end
    end
    prevSimul = !fl && nIn > 0 && pop && expPV;
    if (expReq) mPend = 1;
    if (memReq) begin memPend = 1; pendLeft = lat; memReqAddr = memAddr; end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL R5 watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    for (int l = 1; l <= 3; l++) begin
      for (int st = 0; st < 4; st++) begin
        for (int pp = 0; pp < 4; pp++) begin
          bit p;
          lat = l;
          doReset();
          // start of run: branch to a start address near the wrap point
          step(1'b0, 1'b1, ADDR_W'(8'hFA + st));
          for (int c = 0; c < 48; c++) begin
            case (pp)
              0: p = 1'b1;
              1: p = (c % 2) == 0;
              2: p = (c % 3) != 0;
              default: p = (c >= 24);
            endcase
            if (c == 20)      step(p, 1'b1, ADDR_W'(8'h41 + st));
            else if (c == 21 + l) step(p, 1'b1, ADDR_W'(8'h80 + st));
            else              step(p, 1'b0, '0);
          end
        end
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule